// File: doc/BRIEF.md
# Serial LED Status Shifter

This block drives a three-wire serial LED bus for a drive enclosure: a bit clock, a load strobe and a data line. It stores three status bits for every port: activity, locate and fault. A request carries a port number and a 32-bit status word. The block decodes the status word into that port's three bits. It then sends the whole stored pattern to the enclosure LED controller as one serial frame.

A frame has four parts. First come a configurable number of dummy clock cycles. Next is one clock cycle with the load line high. Then come the data bits, least significant first, three for each configured port. Last are a configurable number of trailing dummy cycles. A remap table chooses which three-bit group of the pattern belongs to each port. Each serial clock cycle is high for a parameterised number of system cycles and then low for the same count.

The request side has no queue. A request is acknowledged in the cycle it is presented, provided no frame is running. While a frame is being sent, new requests are held off. The configuration inputs must stay stable while a frame is in progress.

Top module: `led_status_shifter`

## Requirements
- R1: After reset the pattern is all zeros, busy is low, and ledClk, ledLoad and ledData are all low. All three pins stay low whenever no frame is in progress.
- R2: Port p owns pattern bits 3*m, 3*m+1 and 3*m+2, where m is the 3-bit slot field of cfgSlotMap at bits [3p+2:3p]. Activity is at offset 0, locate at offset 1 and fault at offset 2.
- R3: The activity bit is 1 when status bit 20 or status bit 21 is set, and 0 otherwise. The locate bit copies status bit 19 and the fault bit copies status bit 22. All other status bits have no effect on the pattern.
- R4: The slot number is status bits [11:8]. A request whose slot number is MAX_SLOTS (default 15) or more is acknowledged with reqErr high. Such a request starts no frame and leaves the pattern unchanged.
- R5: Every serial clock cycle holds ledClk high for HALF_CYCLES system cycles and then low for HALF_CYCLES system cycles.
- R6: A frame sends cfgPreClocks cycles with ledLoad low. It then sends exactly one cycle with ledLoad high, then the data cycles, then cfgPostClocks cycles with ledLoad low.
- R7: The data cycles carry pattern bits 0 up to 3*N-1 in that order. N is cfgPortCount, and any count above MAX_PORTS is treated as MAX_PORTS. Each bit is on ledData from the falling clock edge before its cycle until that cycle's falling edge. ledData is 0 in the pre-clock, load and post-clock cycles.
- R8: reqAck is high in a cycle exactly when reqValid is high and no frame is running. A valid request seen while busy is held off without an acknowledge. An accepted request with an in-range slot raises busy on the next cycle.
- R9: The frame sends the pattern as it stood at acceptance. This pattern already includes that request's update. A request waiting during the frame does not alter the bits being sent.
- R10: busy stays high for (cfgPreClocks + 1 + 3*N + cfgPostClocks) * 2 * HALF_CYCLES system cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Update request present |
| reqPort | input | PORT_W (3) | Port whose LED bits are updated |
| reqStatus | input | 32 | Status word holding the slot number and the LED request bits |
| reqAck | output | 1 | Request taken this cycle |
| reqErr | output | 1 | Taken request was rejected because its slot is out of range |
| busy | output | 1 | Frame in progress |
| cfgPortCount | input | PCNT_W (4) | Number of ports shifted out per frame |
| cfgSlotMap | input | MAX_PORTS*PORT_W (24) | Slot index of each port, 3 bits per port |
| cfgPreClocks | input | CLK_CNT_W (8) | Dummy cycles before the load strobe |
| cfgPostClocks | input | CLK_CNT_W (8) | Dummy cycles after the data bits |
| ledClk | output | 1 | Serial bit clock |
| ledLoad | output | 1 | Frame load strobe |
| ledData | output | 1 | Serial data |

## Verification
Each port is updated in turn through each single request bit: bit 20 alone, bit 21 alone, bit 19 and bit 22. The same port is then sent a word that has only unrelated bits set. This separates the OR-ing of the two activity bits from the single-bit copies, and shows that clearing works. The same sweep runs under a reversed slot map and under a scattered slot map. This shows that each group lands where the map says, and not where the port number would put it. Frames are sent with port counts of 0, 1, 3 and 8, and with an oversized count. Pre-clock and post-clock counts include zero and non-zero values, which exercises the frame length and where the load strobe falls. Further tests send an out-of-range slot and a request held off during a frame. These show that rejection leaves later frames unchanged and that the frame in flight keeps its latched contents.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;
  // positions inside the 32-bit status word
  localparam int ACT_A_BIT = 20;
  localparam int ACT_B_BIT = 21;
  localparam int LOC_BIT   = 19;
  localparam int FLT_BIT   = 22;
  localparam int SLOT_LSB  = 8;
  localparam int SLOT_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOAD,
    ST_DATA,
    ST_POST
  } serState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic update;   // accept a valid request: write pattern, latch frame copy
    logic shift;    // present next frame bit on the data line
    logic dataClr;  // return the data line to 0 after the last bit
    logic clkHigh;  // serial clock level
    logic loadOn;   // load strobe level
    logic active;   // frame in progress
  } serStrobe_t;
endpackage

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
  import led_shift_pkg::*;
#(
  parameter int MAX_PORTS   = 8,
  parameter int MAX_SLOTS   = 15,
  parameter int HALF_CYCLES = 12500,
  parameter int CLK_CNT_W   = 8,
  parameter int PCNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [SLOT_W-1:0]    reqSlot,
  input  logic [PCNT_W-1:0]    cfgPortCount,
  input  logic [CLK_CNT_W-1:0] cfgPreClocks,
  input  logic [CLK_CNT_W-1:0] cfgPostClocks,
  output logic                 reqAck,
  output logic                 reqErr,
  output logic                 busy,
  output serStrobe_t           stb
);
  localparam int HCW    = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BITS_W = $clog2(3 * MAX_PORTS + 1);
  localparam int CW     = (CLK_CNT_W > BITS_W) ? CLK_CNT_W : BITS_W;

  serState_e       state, nxtState;
  logic [HCW-1:0]  halfCnt;
  logic            lowPhase;
  logic [CW-1:0]   cycCnt, cycNext, nxtCnt;
  logic [PCNT_W-1:0] portEff;
  logic [CW-1:0]   nBits, preLim, postLim;
  logic            accept, slotOk, halfEnd, fallNow, lastData;

  assign portEff = (cfgPortCount > PCNT_W'(MAX_PORTS)) ? PCNT_W'(MAX_PORTS) : cfgPortCount;
  assign nBits   = CW'(portEff) * CW'(3);
  assign preLim  = CW'(cfgPreClocks);
  assign postLim = CW'(cfgPostClocks);

  assign slotOk  = ({1'b0, reqSlot} < (SLOT_W+1)'(MAX_SLOTS));
  assign accept  = reqValid && (state == ST_IDLE);
  assign reqAck  = accept;
  assign reqErr  = accept && !slotOk;
  assign busy    = (state != ST_IDLE);

  assign halfEnd  = (halfCnt == HCW'(HALF_CYCLES - 1));
  assign fallNow  = busy && halfEnd && !lowPhase;
  assign cycNext  = cycCnt + CW'(1);
  assign lastData = (state == ST_DATA) && (cycNext == nBits);

  always_comb begin
    stb.update  = accept && slotOk;
    stb.shift   = fallNow && (((state == ST_LOAD) && (nBits != '0)) ||
                              ((state == ST_DATA) && !lastData));
    stb.dataClr = fallNow && (((state == ST_LOAD) && (nBits == '0)) || lastData);
    stb.clkHigh = busy && !lowPhase;
    stb.loadOn  = (state == ST_LOAD);
    stb.active  = busy;
  end

  // state reached at the end of the current serial cycle
  always_comb begin
    nxtState = state;
    nxtCnt   = cycNext;
    unique case (state)
      ST_PRE: if (cycNext == preLim) begin
        nxtState = ST_LOAD;
        nxtCnt   = '0;
      end
      ST_LOAD: begin
        nxtCnt = '0;
        if (nBits != '0)        nxtState = ST_DATA;
        else if (postLim != '0) nxtState = ST_POST;
        else                    nxtState = ST_IDLE;
      end
      ST_DATA: if (lastData) begin
        nxtCnt   = '0;
        nxtState = (postLim != '0) ? ST_POST : ST_IDLE;
      end
      ST_POST: if (cycNext == postLim) begin
        nxtState = ST_IDLE;
        nxtCnt   = '0;
      end
      default: begin
        nxtState = ST_IDLE;
        nxtCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      lowPhase <= 1'b0;
      cycCnt   <= '0;
    end else if (stb.update) begin
      state    <= (preLim != '0) ? ST_PRE : ST_LOAD;
      halfCnt  <= '0;
      lowPhase <= 1'b0;
      cycCnt   <= '0;
    end else if (busy) begin
      if (halfEnd) begin
        halfCnt  <= '0;
        lowPhase <= !lowPhase;
        if (lowPhase) begin
          state  <= nxtState;
          cycCnt <= nxtCnt;
        end
      end else begin
        halfCnt <= halfCnt + HCW'(1);
      end
    end
  end

  p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqAck && !reqErr) |=> busy);
  p_reject_no_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqAck && reqErr) |=> !busy);
  p_half_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (halfCnt <= HCW'(HALF_CYCLES - 1)));
  p_high_then_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halfEnd && !lowPhase) |=> (lowPhase && busy));
endmodule

// File: rtl/led_shift_datapath.sv
module led_shift_datapath
  import led_shift_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int PORT_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  serStrobe_t                  stb,
  input  logic [PORT_W-1:0]           reqPort,
  input  logic [1:0]                  actReq,
  input  logic                        locReq,
  input  logic                        fltReq,
  input  logic [MAX_PORTS*PORT_W-1:0] cfgSlotMap,
  output logic                        ledClk,
  output logic                        ledLoad,
  output logic                        ledData
);
  localparam int PAT_W = 3 * MAX_PORTS;

  logic [PAT_W-1:0]     pattern, newPattern, shiftReg;
  logic [PORT_W-1:0]    mapSlot;
  logic [MAX_PORTS-1:0] hit;
  logic                 actOn;

  assign actOn = |actReq;

  always_comb begin
    mapSlot = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      if (reqPort == PORT_W'(p)) mapSlot = cfgSlotMap[p*PORT_W +: PORT_W];
  end

  for (genvar g = 0; g < MAX_PORTS; g++) begin : g_group
    assign hit[g]              = (mapSlot == PORT_W'(g));
    assign newPattern[3*g]     = hit[g] ? actOn  : pattern[3*g];
    assign newPattern[3*g + 1] = hit[g] ? locReq : pattern[3*g + 1];
    assign newPattern[3*g + 2] = hit[g] ? fltReq : pattern[3*g + 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern  <= '0;
      shiftReg <= '0;
      ledData  <= 1'b0;
    end else if (stb.update) begin
      pattern  <= newPattern;
      shiftReg <= newPattern;
      ledData  <= 1'b0;
    end else if (stb.shift) begin
      ledData  <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (stb.dataClr) begin
      ledData  <= 1'b0;
    end
  end

  assign ledClk  = stb.clkHigh;
  assign ledLoad = stb.loadOn;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.active |-> (!ledClk && !ledLoad && !ledData));
  p_pattern_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.update |=> $stable(pattern));
  p_frame_copy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.update && !stb.shift) |=> $stable(shiftReg));
endmodule

// File: rtl/led_status_shifter.sv
module led_status_shifter
  import led_shift_pkg::*;
#(
  parameter int MAX_PORTS   = 8,
  parameter int MAX_SLOTS   = 15,
  parameter int HALF_CYCLES = 12500,
  parameter int CLK_CNT_W   = 8,
  parameter int PORT_W      = $clog2(MAX_PORTS),
  parameter int PCNT_W      = $clog2(MAX_PORTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  input  logic [PORT_W-1:0]           reqPort,
  input  logic [31:0]                 reqStatus,
  output logic                        reqAck,
  output logic                        reqErr,
  output logic                        busy,
  input  logic [PCNT_W-1:0]           cfgPortCount,
  input  logic [MAX_PORTS*PORT_W-1:0] cfgSlotMap,
  input  logic [CLK_CNT_W-1:0]        cfgPreClocks,
  input  logic [CLK_CNT_W-1:0]        cfgPostClocks,
  output logic                        ledClk,
  output logic                        ledLoad,
  output logic                        ledData
);
  serStrobe_t stb;
  logic       unusedStatusBits;

  assign unusedStatusBits = ^{reqStatus[31:23], reqStatus[18:12], reqStatus[7:0]};

  led_shift_ctrl #(
    .MAX_PORTS(MAX_PORTS), .MAX_SLOTS(MAX_SLOTS), .HALF_CYCLES(HALF_CYCLES),
    .CLK_CNT_W(CLK_CNT_W), .PCNT_W(PCNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .reqSlot(reqStatus[SLOT_LSB +: SLOT_W]),
    .cfgPortCount(cfgPortCount), .cfgPreClocks(cfgPreClocks),
    .cfgPostClocks(cfgPostClocks), .reqAck(reqAck), .reqErr(reqErr),
    .busy(busy), .stb(stb)
  );

  led_shift_datapath #(.MAX_PORTS(MAX_PORTS), .PORT_W(PORT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqPort(reqPort),
    .actReq({reqStatus[ACT_B_BIT], reqStatus[ACT_A_BIT]}),
    .locReq(reqStatus[LOC_BIT]), .fltReq(reqStatus[FLT_BIT]),
    .cfgSlotMap(cfgSlotMap), .ledClk(ledClk), .ledLoad(ledLoad), .ledData(ledData)
  );
endmodule

// File: tb/led_status_shifter_tb.sv
module led_status_shifter_tb_top;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqPort = '0;
  logic [31:0] reqStatus = '0;
  logic        reqAck, reqErr, busy;
  logic [3:0]  cfgPortCount = 4'd8;
  logic [23:0] cfgSlotMap = '0;
  logic [7:0]  cfgPreClocks = '0;
  logic [7:0]  cfgPostClocks = '0;
  logic        ledClk, ledLoad, ledData;

  always #2 clk = ~clk;

  led_status_shifter #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPort(reqPort),
    .reqStatus(reqStatus), .reqAck(reqAck), .reqErr(reqErr), .busy(busy),
    .cfgPortCount(cfgPortCount), .cfgSlotMap(cfgSlotMap),
    .cfgPreClocks(cfgPreClocks), .cfgPostClocks(cfgPostClocks),
    .ledClk(ledClk), .ledLoad(ledLoad), .ledData(ledData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // pin monitor
  int   recIdx = 0, busyCnt = 0, highLen = 0, lowLen = 0;
  bit   timingBad = 0;
  bit   recLoad [0:63];
  bit   recData [0:63];
  logic prevClk = 1'b0, holdData = 1'b0;

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (ledClk && !prevClk) begin
      if (recIdx > 0 && lowLen != HALF) timingBad = 1;
      if (recIdx < 64) begin
        recLoad[recIdx] = ledLoad;
        recData[recIdx] = ledData;
      end
      recIdx++;
      highLen = 1;
      holdData = ledData;
    end else if (ledClk) begin
      highLen++;
      if (ledData !== holdData) timingBad = 1;
    end else if (prevClk) begin
      if (highLen != HALF) timingBad = 1;
      lowLen = 1;
    end else begin
      lowLen++;
    end
    prevClk = ledClk;
  end

  // reference model
  logic [23:0] modelPat = '0, expPat = '0;
  int slotMap [0:7];
  int expPre, expPost, expN, expLen;
  bit frameOpen = 0;

  task automatic applyMap();
    for (int p = 0; p < 8; p++) cfgSlotMap[p*3 +: 3] = slotMap[p][2:0];
  endtask

  function automatic logic [31:0] mk(input int slot, input bit a20, input bit a21,
                                     input bit loc, input bit flt, input bit noise);
    logic [31:0] s;
    s = '0;
    s[11:8] = slot[3:0];
    s[20] = a20; s[21] = a21; s[19] = loc; s[22] = flt;
    if (noise) begin s[23] = 1; s[18] = 1; s[0] = 1; s[31] = 1; s[12] = 1; end
    return s;
  endfunction

  task automatic checkFrame();
    int nCyc, badL, badD;
    bit expL, expD;
    nCyc = expPre + 1 + expN + expPost;
    badL = 0; badD = 0;
    chk(recIdx == nCyc, "R6", "serial cycles in frame", recIdx, nCyc);
    for (int k = 0; k < recIdx && k < 64; k++) begin
      expL = (k == expPre);
      expD = (k > expPre && k <= expPre + expN) ? expPat[k - expPre - 1] : 1'b0;
      if (recLoad[k] != expL) badL++;
      if (recData[k] != expD) badD++;
    end
    chk(badL == 0, "R6", "load strobe placement mismatches", badL, 0);
    chk(badD == 0, "R7", "data bit mismatches", badD, 0);
    chk(!timingBad, "R5", "half-period or data hold violation", int'(timingBad), 0);
    chk(busyCnt == expLen, "R10", "busy length", busyCnt, expLen);
  endtask

  task automatic doReq(input int port, input logic [31:0] st, output bit gotErr,
                       output int held);
    int pc;
    @(negedge clk);
    reqPort = port[2:0]; reqStatus = st; reqValid = 1'b1;
    #1;
    held = 0;
    while (!reqAck && held < 5000) begin
      chk(busy, "R8", "ack withheld while idle", int'(busy), 1);
      held++;
      @(negedge clk); #1;
    end
    chk(!busy, "R8", "ack given while busy", int'(busy), 0);
    gotErr = reqErr;
    if (frameOpen) begin checkFrame(); frameOpen = 0; end
    if (!reqErr) begin
      modelPat[3*slotMap[port]]     = st[20] | st[21];
      modelPat[3*slotMap[port] + 1] = st[19];
      modelPat[3*slotMap[port] + 2] = st[22];
      expPat  = modelPat;
      pc      = (int'(cfgPortCount) > 8) ? 8 : int'(cfgPortCount);
      expPre  = int'(cfgPreClocks);
      expPost = int'(cfgPostClocks);
      expN    = 3 * pc;
      expLen  = (expPre + 1 + expN + expPost) * 2 * HALF;
      frameOpen = 1;
    end
    recIdx = 0; busyCnt = 0; timingBad = 0;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitFrame();
    int guard;
    guard = 0;
    @(negedge clk); #1;
    while (busy && guard < 5000) begin guard++; @(negedge clk); #1; end
    checkFrame();
    frameOpen = 0;
  endtask

  task automatic reqFrame(input int port, input logic [31:0] st);
    bit e; int h;
    doReq(port, st, e, h);
    chk(e == 0, "R4", "in-range slot rejected", int'(e), 0);
    waitFrame();
  endtask

  initial begin
    bit e; int h;
    for (int p = 0; p < 8; p++) slotMap[p] = 7 - p;
    applyMap();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!ledClk && !ledLoad && !ledData, "R1", "pins after reset",
        int'({ledClk, ledLoad, ledData}), 0);
    chk(!busy && !reqAck, "R1", "busy/ack after reset", int'({busy, reqAck}), 0);

    // R1: empty update shows an all-zero stored pattern
    reqFrame(0, mk(0, 0, 0, 0, 0, 0));

    // R2/R3 sweep under a reversed map
    for (int p = 0; p < 8; p++) begin
      reqFrame(p, mk(p, 1, 0, 0, 0, 0));
      reqFrame(p, mk(p, 0, 1, 0, 0, 0));
      reqFrame(p, mk(p, 0, 0, 1, 0, 0));
      reqFrame(p, mk(p, 0, 0, 0, 1, 0));
      reqFrame(p, mk(p, 0, 0, 0, 0, 1));   // R3 unrelated bits only: clears
    end
    for (int p = 0; p < 8; p++) reqFrame(p, mk(1, 1, 0, 1, 1, 0));

    // R2 scattered map, short frame with pre and post clocks (R6)
    for (int p = 0; p < 8; p++) slotMap[p] = (p * 3) % 8;
    applyMap();
    cfgPortCount = 4'd3; cfgPreClocks = 8'd2; cfgPostClocks = 8'd3;
    for (int p = 0; p < 8; p++)
      reqFrame(p, mk(p, p[0], 0, !p[0], !p[0], 0));

    // R4 out-of-range slot: rejected, no frame, pattern kept
    doReq(2, mk(15, 1, 1, 1, 1, 0), e, h);
    chk(e == 1, "R4", "slot 15 flagged", int'(e), 1);
    repeat (20) @(negedge clk);
    #1;
    chk(!busy && recIdx == 0, "R4", "rejected request started a frame", recIdx, 0);
    doReq(4, mk(14, 0, 0, 1, 0, 0), e, h);
    chk(e == 0, "R4", "slot 14 accepted", int'(e), 0);
    waitFrame();

    // single port, one pre-clock, identity map
    for (int p = 0; p < 8; p++) slotMap[p] = p;
    applyMap();
    cfgPortCount = 4'd1; cfgPreClocks = 8'd1; cfgPostClocks = 8'd0;
    reqFrame(0, mk(0, 0, 1, 0, 1, 0));
    reqFrame(1, mk(0, 1, 1, 1, 1, 0));

    // R7 zero ports: load cycle then post-clocks only
    cfgPortCount = 4'd0; cfgPreClocks = 8'd0; cfgPostClocks = 8'd2;
    reqFrame(5, mk(0, 1, 0, 0, 0, 0));

    // R7 oversized count clamps to eight ports
    cfgPortCount = 4'd12; cfgPostClocks = 8'd1;
    reqFrame(7, mk(0, 0, 0, 1, 1, 0));

    // R8/R9 request held off during a frame, frame keeps its latched copy
    cfgPortCount = 4'd8; cfgPreClocks = 8'd0; cfgPostClocks = 8'd0;
    doReq(3, mk(3, 1, 0, 0, 0, 0), e, h);
    doReq(5, mk(5, 0, 0, 1, 1, 0), e, h);
    chk(h > 0, "R8", "second request was not held off", h, 1);
    chk(e == 0, "R9", "held request rejected", int'(e), 0);
    waitFrame();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule